// File: doc/BRIEF.md
# Redundant Heater Line Thermal Controller

This block keeps one thermal line inside a temperature band. Three redundant digital temperature samples arrive every clock. The controller takes their median, so a single sensor that is stuck or wrong cannot steer the regulation. A hysteresis comparator uses that median to turn the heater on or off. Its output drives one of two heater paths, nominal or redundant, and only one path is in use at a time.

Single-cycle command pulses switch the line on and off and switch fault monitoring on and off. While monitoring is on, a fault flag on the nominal heater path moves regulation to the redundant heater. A build-time option decides what happens after that. With the option off, the failover is permanent. With it on, the controller returns to the nominal heater once the fault flag clears, which covers transient failures.

Each sample also gets a plausibility flag, raised when the sample sits at either end of the code range. The flags are reported only and do not cause any reconfiguration. Every output is registered and reflects the inputs seen at the previous rising clock edge.

Top module: `therm_line_ctrl`

## Requirements
- R1: The regulation decision uses the median of the three samples. One sample that is far away from the other two, in either direction, does not change the heater decision.
- R2: When the line is enabled, the heater demand behaves as follows. It turns on at an edge where the median is strictly below LO_THR. It turns off at an edge where the median is strictly above HI_THR. For a median from LO_THR to HI_THR inclusive, it keeps its previous value.
- R3: The two heater outputs are never on together. `heat_nom` can be on only while `sel_red` is 0, and `heat_red` can be on only while `sel_red` is 1.
- R4: Suppose that at a rising edge monitoring is enabled, the line stays enabled and `flt_nom` is 1. Then `sel_red` is 1 after that edge, the nominal heater is off, and the redundant heater carries the demand.
- R5: A pulse on `cmd_line_on` or `cmd_line_off` sets or clears `line_en` at the next edge. A pulse on `cmd_mon_on` or `cmd_mon_off` does the same for `mon_en`. If both pulses of a pair are high together, the off command wins.
- R6: After a synchronous reset, all outputs are 0. This means the line is disabled, monitoring is disabled and the nominal heater is selected.
- R7: With REVERT_EN=0, `sel_red` never returns to 0 except through reset. With REVERT_EN=1, `sel_red` returns to 0 at the first edge where the line is enabled, monitoring is enabled and `flt_nom` is 0.
- R8: While the line is disabled, both heater outputs are 0 and `sel_red` does not change. The heater demand is also cleared, so after re-enabling with a median inside the band, both heaters stay off.
- R9: Bit i of `sens_flt` is 1 one cycle after sample i equals 0 or the all-ones code. Bit 0 belongs to `t_a`, bit 1 to `t_b` and bit 2 to `t_c`. These flags never change `sel_red`.
- R10: `flt_nom` is ignored while `mon_en` is 0, and that includes the cycle in which `cmd_mon_on` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| t_a | input | TW | Temperature sample, sensor A |
| t_b | input | TW | Temperature sample, sensor B |
| t_c | input | TW | Temperature sample, sensor C |
| cmd_line_on | input | 1 | Pulse: enable the line |
| cmd_line_off | input | 1 | Pulse: disable the line |
| cmd_mon_on | input | 1 | Pulse: enable fault monitoring |
| cmd_mon_off | input | 1 | Pulse: disable fault monitoring |
| flt_nom | input | 1 | Fault flag for the nominal heater path |
| heat_nom | output | 1 | Nominal heater is driven |
| heat_red | output | 1 | Redundant heater is driven |
| line_en | output | 1 | Line is enabled |
| mon_en | output | 1 | Monitoring is enabled |
| sel_red | output | 1 | 0: nominal heater selected, 1: redundant heater selected |
| sens_flt | output | 3 | Per-sensor range-end flags |

## Verification
The assertions take for granted that the command pulses and the fault flag are synchronous to `clk` and stable around the rising edge. They also assume the threshold parameters satisfy LO_THR < HI_THR, since every demand property relies on that band. The stimulus changes inputs only one nanosecond after a rising edge and keeps the default thresholds at 100 and 140. Two instances share the same stimulus, one with reversion on and one with it off, so the permanent and the transient failover behaviours are compared on the same fault sequence.

// File: rtl/therm_pkg.sv
package therm_pkg;

  // Heater path selection; the encoding is visible on the sel_red port.
  typedef enum logic {
    PATH_NOM = 1'b0,
    PATH_RED = 1'b1
  } path_e;

  // Set/clear latch for command pulses; the clear pulse has priority.
  function automatic logic latch_cmd(input logic cur, input logic set, input logic clr);
    return clr ? 1'b0 : (set ? 1'b1 : cur);
  endfunction

endpackage

// File: rtl/tl_median3.sv
module tl_median3 #(
  parameter int TW = 8
) (
  input  logic [TW-1:0] a,
  input  logic [TW-1:0] b,
  input  logic [TW-1:0] c,
  output logic [TW-1:0] med
);
  logic [TW-1:0] lo_ab, hi_ab, hi_lo;

  // median = max(min(a,b), min(max(a,b), c))
  always_comb begin
    lo_ab = (a < b) ? a : b;
    hi_ab = (a < b) ? b : a;
    hi_lo = (hi_ab < c) ? hi_ab : c;
    med   = (lo_ab > hi_lo) ? lo_ab : hi_lo;
  end
endmodule

// File: rtl/tl_hyst.sv
module tl_hyst #(
  parameter int TW     = 8,
  parameter int LO_THR = 100,
  parameter int HI_THR = 140
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [TW-1:0] med,
  output logic          dem_nxt
);
  localparam logic [TW-1:0] LO_T = TW'(LO_THR);
  localparam logic [TW-1:0] HI_T = TW'(HI_THR);

  logic dem_q;

  always_comb begin
    if (!en)             dem_nxt = 1'b0;
    else if (med < LO_T) dem_nxt = 1'b1;
    else if (med > HI_T) dem_nxt = 1'b0;
    else                 dem_nxt = dem_q;
  end

  always_ff @(posedge clk) begin
    if (rst) dem_q <= 1'b0;
    else     dem_q <= dem_nxt;
  end
endmodule

// File: rtl/tl_path_sel.sv
module tl_path_sel
  import therm_pkg::*;
#(
  parameter bit REVERT_EN = 1'b0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  line_on,
  input  logic  mon_on,
  input  logic  flt,
  output path_e sel_nxt,
  output path_e sel_q
);
  always_comb begin
    sel_nxt = sel_q;
    if (line_on && mon_on) begin
      if (flt)            sel_nxt = PATH_RED;
      else if (REVERT_EN) sel_nxt = PATH_NOM;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sel_q <= PATH_NOM;
    else     sel_q <= sel_nxt;
  end
endmodule

// File: rtl/therm_line_ctrl.sv
module therm_line_ctrl
  import therm_pkg::*;
#(
  parameter int TW        = 8,
  parameter int LO_THR    = 100,
  parameter int HI_THR    = 140,
  parameter bit REVERT_EN = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] t_a,
  input  logic [TW-1:0] t_b,
  input  logic [TW-1:0] t_c,
  input  logic          cmd_line_on,
  input  logic          cmd_line_off,
  input  logic          cmd_mon_on,
  input  logic          cmd_mon_off,
  input  logic          flt_nom,
  output logic          heat_nom,
  output logic          heat_red,
  output logic          line_en,
  output logic          mon_en,
  output logic          sel_red,
  output logic [2:0]    sens_flt
);
  localparam int NS = 3;
  localparam logic [TW-1:0] CODE_MAX = {TW{1'b1}};

  logic [TW-1:0] samp [NS];
  logic [TW-1:0] med_w;
  logic          line_nxt, dem_nxt;
  path_e         sel_nxt, sel_q;

  assign samp[0] = t_a;
  assign samp[1] = t_b;
  assign samp[2] = t_c;

  tl_median3 #(.TW(TW)) u_med (
    .a(t_a), .b(t_b), .c(t_c), .med(med_w)
  );

  assign line_nxt = latch_cmd(line_en, cmd_line_on, cmd_line_off);

  tl_hyst #(.TW(TW), .LO_THR(LO_THR), .HI_THR(HI_THR)) u_hyst (
    .clk(clk), .rst(rst), .en(line_nxt), .med(med_w), .dem_nxt(dem_nxt)
  );

  tl_path_sel #(.REVERT_EN(REVERT_EN)) u_sel (
    .clk(clk), .rst(rst), .line_on(line_nxt), .mon_on(mon_en),
    .flt(flt_nom), .sel_nxt(sel_nxt), .sel_q(sel_q)
  );

  assign sel_red = (sel_q == PATH_RED);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_en  <= 1'b0;
      mon_en   <= 1'b0;
      heat_nom <= 1'b0;
      heat_red <= 1'b0;
    end else begin
      line_en  <= line_nxt;
      mon_en   <= latch_cmd(mon_en, cmd_mon_on, cmd_mon_off);
      heat_nom <= dem_nxt && (sel_nxt == PATH_NOM);
      heat_red <= dem_nxt && (sel_nxt == PATH_RED);
    end
  end

  for (genvar i = 0; i < NS; i++) begin : g_sflt
    always_ff @(posedge clk) begin
      if (rst) sens_flt[i] <= 1'b0;
      else     sens_flt[i] <= (samp[i] == '0) || (samp[i] == CODE_MAX);
    end
  end
endmodule

// File: rtl/therm_line_chk.sv
module therm_line_chk #(
  parameter int TW        = 8,
  parameter int LO_THR    = 100,
  parameter int HI_THR    = 140,
  parameter bit REVERT_EN = 1'b0
) (
  input logic          clk,
  input logic          rst,
  input logic [TW-1:0] med,
  input logic          cmd_line_on,
  input logic          cmd_line_off,
  input logic          flt_nom,
  input logic          heat_nom,
  input logic          heat_red,
  input logic          line_en,
  input logic          mon_en,
  input logic          sel_red
);
  localparam logic [TW-1:0] LO_T = TW'(LO_THR);
  localparam logic [TW-1:0] HI_T = TW'(HI_THR);

  assert_excl_heat_R3: assert property (@(posedge clk) disable iff (rst)
    !(heat_nom && heat_red));

  assert_nom_gated_R3: assert property (@(posedge clk) disable iff (rst)
    heat_nom |-> !sel_red);

  assert_failover_R4: assert property (@(posedge clk) disable iff (rst)
    (line_en && !cmd_line_off && mon_en && flt_nom) |=> (sel_red && !heat_nom));

  assert_heat_on_R2: assert property (@(posedge clk) disable iff (rst)
    (line_en && !cmd_line_off && !sel_red && !(mon_en && flt_nom) && med < LO_T)
      |=> heat_nom);

  assert_heat_off_R2: assert property (@(posedge clk) disable iff (rst)
    (med > HI_T) |=> (!heat_nom && !heat_red));

  assert_dis_off_R8: assert property (@(posedge clk) disable iff (rst)
    !line_en |-> (!heat_nom && !heat_red));

  assert_dis_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!line_en && !cmd_line_on) |=> $stable(sel_red));

  assert_mon_off_R10: assert property (@(posedge clk) disable iff (rst)
    (!mon_en && !sel_red) |=> !sel_red);

  if (!REVERT_EN) begin : g_perm
    assert_no_revert_R7: assert property (@(posedge clk) disable iff (rst)
      sel_red |=> sel_red);
  end else begin : g_rev
    assert_revert_R7: assert property (@(posedge clk) disable iff (rst)
      (sel_red && line_en && !cmd_line_off && mon_en && !flt_nom) |=> !sel_red);
  end
endmodule

bind therm_line_ctrl therm_line_chk #(
  .TW(TW), .LO_THR(LO_THR), .HI_THR(HI_THR), .REVERT_EN(REVERT_EN)
) u_chk (
  .clk(clk), .rst(rst), .med(med_w), .cmd_line_on(cmd_line_on),
  .cmd_line_off(cmd_line_off), .flt_nom(flt_nom), .heat_nom(heat_nom),
  .heat_red(heat_red), .line_en(line_en), .mon_en(mon_en), .sel_red(sel_red)
);

// File: tb/tb_therm_line_ctrl.sv
module tb_therm_line_ctrl;
  localparam int TW = 8;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [TW-1:0] t_a = 8'd120, t_b = 8'd120, t_c = 8'd120;
  logic c_lon = 0, c_loff = 0, c_mon = 0, c_moff = 0, flt = 0;
  logic hn, hr, le, me, sr, hn2, hr2, le2, me2, sr2;
  logic [2:0] sf, sf2;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  therm_line_ctrl #(.TW(TW), .LO_THR(100), .HI_THR(140), .REVERT_EN(1'b0)) dut (
    .clk(clk), .rst(rst), .t_a(t_a), .t_b(t_b), .t_c(t_c),
    .cmd_line_on(c_lon), .cmd_line_off(c_loff), .cmd_mon_on(c_mon),
    .cmd_mon_off(c_moff), .flt_nom(flt), .heat_nom(hn), .heat_red(hr),
    .line_en(le), .mon_en(me), .sel_red(sr), .sens_flt(sf));

  therm_line_ctrl #(.TW(TW), .LO_THR(100), .HI_THR(140), .REVERT_EN(1'b1)) dut_rv (
    .clk(clk), .rst(rst), .t_a(t_a), .t_b(t_b), .t_c(t_c),
    .cmd_line_on(c_lon), .cmd_line_off(c_loff), .cmd_mon_on(c_mon),
    .cmd_mon_off(c_moff), .flt_nom(flt), .heat_nom(hn2), .heat_red(hr2),
    .line_en(le2), .mon_en(me2), .sel_red(sr2), .sens_flt(sf2));

  // {a, b, c, flt, hn, hr, sel, hn_rv, hr_rv, sel_rv}
  localparam logic [30:0] VEC [NV] = '{
    {8'd120, 8'd120, 8'd120, 1'b0, 3'b000, 3'b000},
    {8'd90,  8'd95,  8'd200, 1'b0, 3'b100, 3'b100},
    {8'd120, 8'd130, 8'd110, 1'b0, 3'b100, 3'b100},
    {8'd150, 8'd145, 8'd10,  1'b0, 3'b000, 3'b000},
    {8'd140, 8'd140, 8'd140, 1'b0, 3'b000, 3'b000},
    {8'd99,  8'd255, 8'd0,   1'b0, 3'b100, 3'b100},
    {8'd100, 8'd100, 8'd100, 1'b0, 3'b100, 3'b100},
    {8'd141, 8'd0,   8'd255, 1'b0, 3'b000, 3'b000},
    {8'd50,  8'd50,  8'd50,  1'b0, 3'b100, 3'b100},
    {8'd50,  8'd50,  8'd50,  1'b1, 3'b011, 3'b011},
    {8'd50,  8'd50,  8'd50,  1'b0, 3'b011, 3'b100},
    {8'd200, 8'd200, 8'd200, 1'b0, 3'b001, 3'b000}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    c_lon = 0; c_loff = 0; c_mon = 0; c_moff = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
    chk("R6 heat_nom", {7'd0, hn}, 8'd0);
    chk("R6 heat_red", {7'd0, hr}, 8'd0);
    chk("R6 line_en/mon_en", {6'd0, le, me}, 8'd0);
    chk("R6 sel_red", {6'd0, sr, sr2}, 8'd0);
    chk("R6 sens_flt", {5'd0, sf}, 8'd0);
  endtask

  function automatic logic [2:0] exp_sf(input logic [TW-1:0] a, b, c);
    return {(c == 0 || c == 8'hFF), (b == 0 || b == 8'hFF), (a == 0 || a == 8'hFF)};
  endfunction

  initial begin
    #1;
    do_reset();

    // R5: enable line and monitoring
    c_lon = 1; c_mon = 1;
    step();
    chk("R5 line_en set", {7'd0, le}, 8'd1);
    chk("R5 mon_en set", {7'd0, me}, 8'd1);

    // Table walk: R1 median, R2 hysteresis, R4 failover, R7 revert, R9 flags
    for (int i = 0; i < NV; i++) begin
      {t_a, t_b, t_c, flt} = VEC[i][30:6];
      step();
      chk($sformatf("R1/R2 step %0d heat_nom", i), {7'd0, hn}, {7'd0, VEC[i][5]});
      chk($sformatf("R3/R4 step %0d heat_red", i), {7'd0, hr}, {7'd0, VEC[i][4]});
      chk($sformatf("R4/R7 step %0d sel_red", i), {7'd0, sr}, {7'd0, VEC[i][3]});
      chk($sformatf("R7 step %0d revert inst", i), {5'd0, hn2, hr2, sr2}, {5'd0, VEC[i][2:0]});
      chk($sformatf("R9 step %0d sens_flt", i), {5'd0, sf}, {5'd0, exp_sf(t_a, t_b, t_c)});
    end

    // R8: disable while heating, fault present: heaters off, selection held
    t_a = 50; t_b = 50; t_c = 50; flt = 0;
    step();
    chk("R2 redundant heats", {6'd0, hr, hn2}, 8'd3);
    c_loff = 1; flt = 1;
    step();
    chk("R8 heaters off", {4'd0, hn, hr, hn2, hr2}, 8'd0);
    chk("R8 line_en cleared", {6'd0, le, le2}, 8'd0);
    chk("R8 sel held", {6'd0, sr, sr2}, 8'b10);
    flt = 0;

    // R5: simultaneous on/off, off wins
    c_lon = 1; c_loff = 1;
    step();
    chk("R5 off wins", {7'd0, le}, 8'd0);

    // R8: demand cleared; re-enable inside band keeps heaters off
    t_a = 120; t_b = 120; t_c = 120;
    c_lon = 1;
    step();
    chk("R8 re-enable line", {7'd0, le}, 8'd1);
    chk("R8 demand cleared", {6'd0, hr, hn2}, 8'd0);

    // R10: fault ignored while monitoring is off
    do_reset();
    t_a = 50; t_b = 50; t_c = 50;
    c_lon = 1;
    step();
    chk("R2 nominal heats", {7'd0, hn}, 8'd1);
    flt = 1;
    step();
    chk("R10 fault ignored", {6'd0, sr, hn}, 8'b01);
    c_mon = 1;
    step();
    chk("R10 same-cycle enable ignored", {6'd0, me, sr}, 8'b10);
    step();
    chk("R4 failover", {5'd0, sr, hr, hn}, 8'b110);
    chk("R4 failover revert inst", {6'd0, sr2, hr2}, 8'b11);
    c_moff = 1; c_mon = 1;
    step();
    chk("R5 mon off wins", {7'd0, me}, 8'd0);
    flt = 0;
    step();
    chk("R7 no revert without monitoring", {7'd0, sr2}, 8'd1);
    c_mon = 1;
    step();
    step();
    chk("R7 revert inst returns", {6'd0, sr2, hn2}, 8'b01);
    chk("R7 permanent inst holds", {6'd0, sr, hr}, 8'b11);

    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule